// File: doc/BRIEF.md
# Conditional Serial Pattern Detector

This block watches a single-bit serial stream, taking one bit on every rising clock edge. It raises its output while the three most recent bits, oldest first, are 0 then 1 then 0. Matches may overlap, so a trailing 0 can also serve as the first bit of the next match. The bit sequence 1, 0, 0 acts as a lockout. Once those three bits have arrived in a row at any point since reset, the output stays low for good, whatever bits follow. Only a reset ends the lockout.

The design is a Moore machine with seven reachable states held in a three-bit register. The output comes from its own flip-flop, which is loaded in step with the state register. The output therefore depends only on the state and never follows the input within a cycle. A caller drives one bit per clock and reads the output after the edge that took that bit in. Reset is synchronous and active low.

Top module: `pattern_lockout_det`

## Requirements
- R1: When rst_n is low at a rising edge, z_out is 0 after that edge and the detector returns to its start state. This holds even if z_out was 1 before the edge.
- R2: After the edge that samples the third bit of a 0,1,0 run, z_out is 1, provided no 1,0,0 run has occurred since reset. It stays 1 until the next edge.
- R3: Matches overlap. After reset, the input 0,1,0,1,0,1,0 gives z_out = 0,0,1,0,1,0,1, one value after each edge.
- R4: Once the bits 1,0,0 have been sampled in a row since reset, z_out stays 0 on every later edge until reset. This includes later 0,1,0 runs.
- R5: A run of leading 0s does not block detection. After reset, the input 0,0,0,0,1,0 gives a 1 only after the last bit.
- R6: A run of leading 1s does not block detection. After reset, the input 1,1,1,0,1,0 gives a 1 only after the last bit, because no 1,0,0 run is present.
- R7: A match needs three sampled bits since reset. After reset, the input 1,0 gives z_out = 0,0.
- R8: The input 0,0,1,0,1,0,1,0,0,1,0 gives 0,0,0,1,0,1,0,1,0,0,0. The input 1,1,0,1,1,0,1,0,0,1,0 gives 0,0,0,0,0,0,0,1,0,0,0.
- R9: A reset from the locked-out condition restores detection. After it, the input 0,1,0 gives a 1 after the third bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Bits are sampled on the rising edge. |
| rst_n | input | 1 | Synchronous reset, active low. |
| x_in | input | 1 | Serial data bit. |
| z_out | output | 1 | Registered match flag. |

## Verification
The bound checker watches state-level rules on every clock cycle:
- A reset edge always clears the output.
- Taking a 0 in the state that has seen 0,1 always raises the output.
- The locked-out state never leaves and never drives a 1.
- Taking a 0 in either state whose recent bits end in 1,0 always locks the machine out.
- A high output always follows a sampled 0.
- The unused state code never appears.

End-to-end output sequences need the bench scenarios, which compare z_out against a model that keeps the last three bits and a sticky lockout flag. These sequences cover the two long reference streams, overlapping matches, leading runs of 0s and 1s, too few bits after reset, and recovery from lockout.

// File: rtl/ldet_pkg.sv
// Package: shared state encoding for the conditional pattern detector.
// Assumes a three-bit state code; code 7 is unused and must never be held.
package ldet_pkg;
    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_START = 3'd0,  // nothing useful seen since reset
        ST_Z     = 3'd1,  // recent bits end in 0, no 1 yet in this run
        ST_ZO    = 3'd2,  // recent bits end in 0,1
        ST_MATCH = 3'd3,  // recent bits are 0,1,0; output high
        ST_O     = 3'd4,  // recent bits end in 1
        ST_OZ    = 3'd5,  // recent bits end in 1,0
        ST_LOCK  = 3'd6,  // 1,0,0 seen: absorbing
        ST_SPARE = 3'd7   // unused code
    } det_state_e;
endpackage

// File: rtl/ldet_next_state.sv
// Module: ldet_next_state
// Pure combinational transition function of the detector.
// Assumes the state input is registered elsewhere; the unused code
// falls back to the start state.
module ldet_next_state
    import ldet_pkg::*;
(
    input  det_state_e cur_state,
    input  logic       bit_in,
    output det_state_e nxt_state
);
    // Purpose: map (current state, sampled bit) to the next state.
    always_comb begin
        case (cur_state)
            ST_START: nxt_state = bit_in ? ST_O  : ST_Z;
            ST_Z:     nxt_state = bit_in ? ST_ZO : ST_Z;
            ST_ZO:    nxt_state = bit_in ? ST_O  : ST_MATCH;
            ST_MATCH: nxt_state = bit_in ? ST_ZO : ST_LOCK;
            ST_O:     nxt_state = bit_in ? ST_O  : ST_OZ;
            ST_OZ:    nxt_state = bit_in ? ST_ZO : ST_LOCK;
            ST_LOCK:  nxt_state = ST_LOCK;
            default:  nxt_state = ST_START;
        endcase
    end
endmodule

// File: rtl/ldet_state_reg.sv
// Module: ldet_state_reg
// Holds the detector state. Reset is synchronous, active low, and
// loads the start state.
module ldet_state_reg
    import ldet_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  det_state_e d_state,
    output det_state_e q_state
);
    // Purpose: register the next state, or the start state on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q_state <= ST_START;
        else        q_state <= d_state;
    end
endmodule

// File: rtl/ldet_out_reg.sv
// Module: ldet_out_reg
// Registered Moore output, decoded from the next state so that it
// updates on the same edge as the state register. Reset clears it.
module ldet_out_reg
    import ldet_pkg::*;
#(
    parameter det_state_e FLAG_STATE = ST_MATCH
) (
    input  logic       clk,
    input  logic       rst_n,
    input  det_state_e d_state,
    output logic       flag_q
);
    logic flag_d;

    // Purpose: decode the single state that drives the output high.
    always_comb flag_d = (d_state == FLAG_STATE);

    // Purpose: hold the output flag, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end
endmodule

// File: rtl/pattern_lockout_det.sv
// Module: pattern_lockout_det
// Serial detector: z_out is high while the last three bits are 0,1,0,
// unless 1,0,0 has occurred since reset. One bit is sampled per clock.
// Assumes rst_n is synchronous and active low.
module pattern_lockout_det
    import ldet_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic x_in,
    output logic z_out
);
    det_state_e state_q;
    det_state_e state_d;

    ldet_next_state u_next (
        .cur_state (state_q),
        .bit_in    (x_in),
        .nxt_state (state_d)
    );

    ldet_state_reg u_sreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_state (state_d),
        .q_state (state_q)
    );

    ldet_out_reg #(.FLAG_STATE(ST_MATCH)) u_oreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_state (state_d),
        .flag_q  (z_out)
    );
endmodule

// File: rtl/pattern_lockout_det_chk.sv
// Module: pattern_lockout_det_chk
// Assertion checker bound into pattern_lockout_det.
// Assumes it sees the internal state register through the bind.
module pattern_lockout_det_chk
    import ldet_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       x_in,
    input logic       z_out,
    input det_state_e state_q
);
    logic edge_seen = 1'b0;

    // Purpose: mark that at least one clock edge has passed.
    always_ff @(posedge clk) edge_seen <= 1'b1;

    // R1: a reset edge clears the output and returns to start
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (!edge_seen)
        !rst_n |=> (!z_out && state_q == ST_START));

    // R2: a 0 taken after 0,1 raises the output
    a_r2_match_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ZO && !x_in) |=> z_out);

    // R2: a high output always follows a sampled 0
    a_r2_after_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(z_out) |-> !$past(x_in));

    // R4: the locked-out state is absorbing and silent
    a_r4_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK) |=> (state_q == ST_LOCK && !z_out));

    // R4: 1,0 followed by 0 locks the machine out
    a_r4_lock_entry: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_MATCH || state_q == ST_OZ) && !x_in) |=> (state_q == ST_LOCK));

    // R3: a 1 taken in the match state lowers the output
    a_r3_overlap_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MATCH && x_in) |=> (!z_out && state_q == ST_ZO));

    // R1: the unused code is never held once out of reset
    a_r1_no_spare: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != ST_SPARE);
endmodule

bind pattern_lockout_det pattern_lockout_det_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .x_in    (x_in),
    .z_out   (z_out),
    .state_q (state_q)
);

// File: tb/pattern_lockout_det_tb.sv
// Bench: a scoreboard. A driver task applies bits and pushes the
// expected output from an independent model; a monitor pops and
// compares after each clock edge.
module pattern_lockout_det_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic x_in = 1'b0;
    logic z_out;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    item_t exp_q[$];
    int    checks = 0;
    int    fails = 0;
    bit    finished = 0;

    // Reference model state
    logic [2:0] hist = 3'b000;
    int         nbits = 0;
    bit         sticky = 0;

    pattern_lockout_det u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .x_in  (x_in),
        .z_out (z_out)
    );

    // Purpose: 100 MHz clock
    always #5 clk = ~clk;

    // Purpose: apply one bit (or reset cycle) and queue the expected output.
    task automatic drive(input logic b, input logic rl, input string tag);
        item_t it;
        @(negedge clk);
        rst_n = rl;
        x_in  = b;
        if (!rl) begin
            hist = 3'b000; nbits = 0; sticky = 0;
            it.exp = 1'b0;
        end else begin
            hist = {hist[1:0], b};
            if (nbits < 3) nbits++;
            if (nbits >= 3 && hist == 3'b100) sticky = 1;
            it.exp = (nbits >= 3 && hist == 3'b010 && !sticky);
        end
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic do_reset(input string tag);
        drive(1'b0, 1'b0, tag);
        drive(1'b0, 1'b0, tag);
    endtask

    task automatic send(input string bits, input string tag);
        for (int i = 0; i < bits.len(); i++)
            drive(bits[i] == "1", 1'b1, tag);
    endtask

    // Purpose: monitor pops one expected item per edge and compares.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            checks++;
            if (z_out !== it.exp) begin
                fails++;
                $display("FAIL %s z_out actual=%b expected=%b at %0t",
                         it.tag, z_out, it.exp, $time);
            end
        end
    end

    // Purpose: stimulus sequence covering each requirement.
    initial begin
        do_reset("R1");
        send("10", "R7");
        do_reset("R1");
        send("000010", "R5");
        do_reset("R1");
        send("111010", "R6");
        do_reset("R1");
        send("0101010", "R3");
        send("0", "R4");
        send("1010", "R4");
        send("00101", "R4");
        do_reset("R9");
        send("010", "R9");
        do_reset("R1");
        send("00101010010", "R8");
        do_reset("R1");
        send("11011010010", "R8");
        do_reset("R1");
        send("010", "R2");
        drive(1'b0, 1'b0, "R1");
        send("0010", "R2");
        @(negedge clk);
        rst_n = 1'b1;
        x_in  = 1'b1;
        repeat (3) @(posedge clk);
        #3;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R2 scoreboard left=%0d expected=0", exp_q.size());
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Purpose: watchdog ends a hung run as a failure.
    initial begin
        #(200000 * 10);
        if (!finished) begin
            fails++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule